// File: doc/BRIEF.md
# Thread Context Switch Scheduler

This block chooses which of eight hardware thread contexts may issue into a single shared packet-processing pipeline. Only one context issues at a time. The active context raises a stall request when it waits on a long-latency reference, such as a memory or I/O access. The scheduler then marks that context as blocked and searches the other contexts in circular order, starting after the stalling one. It hands the pipeline to the first context that is free to run.

Every switch costs a fixed drain window of three cycles, during which nothing issues. If no context can run, the engine drops into an idle state. It stays there until an unblock pulse arrives for any context, then selects that context and pays the same drain window before issue resumes. Unblock pulses come from the units that complete outstanding references. They may arrive at any time and are recorded per context.

Top module: `ctx_switch_sched`

## Requirements
- R1: In the first cycle after reset, the active context is 0, the issue flag is high, the idle flag is low, and all eight contexts are free to run.
- R2: A stall sampled while issuing switches the pipeline to the first free context found by counting upward from the stalling context plus one, modulo 8.
- R3: After any switch, the issue flag stays low for exactly 3 cycles, and the new context ID is visible from the first of them.
- R4: A context that stalled is skipped by every later search until an unblock pulse for it has been received.
- R5: If a stall finds no other free context, the idle flag rises and the issue flag falls in the next cycle. Both stay so, with the context ID unchanged, for as long as no unblock pulse arrives.
- R6: An unblock pulse seen while idle selects that context, with the stalled context itself checked last. Idle falls in the next cycle, and the 3-cycle drain follows before issue resumes.
- R7: When an unblock pulse for the active context and a stall from it arrive in the same cycle, the stall wins and the context stays blocked.
- R8: A stall request while the issue flag is low (draining or idle) has no effect.
- R9: An unblock pulse received while issuing or draining is remembered, so a later search may select that context.
- R10: While issuing with no stall request, the issue flag stays high and the context ID does not change in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Stall request from the active context |
| unblock_i | input | NUM_CTX | One-cycle pulse per context: its outstanding reference has completed |
| active_id_o | output | $clog2(NUM_CTX) | Context that owns or is about to own the pipeline |
| issue_valid_o | output | 1 | High when the active context may issue this cycle |
| idle_o | output | 1 | High when no context can run |

## Verification
The assertions assume that stall_i is meaningful only while the issue flag is high. They also assume that unblock pulses are single-cycle events, which need not be cleared between uses. The bench raises stalls during drain and idle on purpose, only to show that they are ignored. It raises unblock pulses only for contexts whose effect it can observe: a context that is blocked, or one stalled in the same cycle. Every expected context ID is derived from the circular search order. The bench never steers the engine into idle except by stalling through every free context.

// File: rtl/ctx_sched_pkg.sv
package ctx_sched_pkg;
   typedef enum logic [1:0] {
      MODE_RUN   = 2'd0,
      MODE_DRAIN = 2'd1,
      MODE_IDLE  = 2'd2
   } sched_mode_e;
endpackage

// File: rtl/ctx_rr_pick.sv
// Circular first-free search: offsets 1..N from the base, so the base itself is tried last.
module ctx_rr_pick #(
   parameter int N   = 8,
   parameter int IDW = $clog2(N)
) (
   input  logic [N-1:0]   cand_i,
   input  logic [IDW-1:0] base_i,
   output logic           found_o,
   output logic [IDW-1:0] pick_o
);
   always_comb begin
      found_o = 1'b0;
      pick_o  = base_i;
      for (int off = N; off >= 1; off--) begin
         logic [IDW-1:0] idx;
         idx = base_i + off[IDW-1:0];
         if (cand_i[idx]) begin
            found_o = 1'b1;
            pick_o  = idx;
         end
      end
   end
endmodule

// File: rtl/ctx_drain_timer.sv
module ctx_drain_timer #(
   parameter int CYCLES = 3,
   parameter int CW     = $clog2(CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic done_o
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= CW'(CYCLES - 1);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);
endmodule

// File: rtl/ctx_switch_sched.sv
module ctx_switch_sched
   import ctx_sched_pkg::*;
#(
   parameter int NUM_CTX      = 8,
   parameter int DRAIN_CYCLES = 3,
   parameter int IDW          = $clog2(NUM_CTX)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               stall_i,
   input  logic [NUM_CTX-1:0] unblock_i,
   output logic [IDW-1:0]     active_id_o,
   output logic               issue_valid_o,
   output logic               idle_o
);
   generate
      if (NUM_CTX < 2 || (1 << IDW) != NUM_CTX)
         $error("NUM_CTX must be a power of two of at least 2");
      if (DRAIN_CYCLES < 1)
         $error("DRAIN_CYCLES must be at least 1");
   endgenerate

   sched_mode_e        mode_q, mode_d;
   logic [IDW-1:0]     act_q, act_d;
   logic [NUM_CTX-1:0] free_q, free_d;
   logic [NUM_CTX-1:0] cand;
   logic               stall_take;
   logic               found;
   logic [IDW-1:0]     pick;
   logic               drain_done;
   logic               load_drain;

   assign stall_take = (mode_q == MODE_RUN) && stall_i;

   // per-context blocked tracking; a same-cycle stall overrides an unblock
   genvar gi;
   generate
      for (gi = 0; gi < NUM_CTX; gi++) begin : g_ctx
         always_comb begin
            if (stall_take && (act_q == IDW'(gi)))
               free_d[gi] = 1'b0;
            else
               free_d[gi] = free_q[gi] | unblock_i[gi];
         end
         assign cand[gi] = free_d[gi];
      end
   endgenerate

   ctx_rr_pick #(.N(NUM_CTX), .IDW(IDW)) u_pick (
      .cand_i  (cand),
      .base_i  (act_q),
      .found_o (found),
      .pick_o  (pick)
   );

   ctx_drain_timer #(.CYCLES(DRAIN_CYCLES)) u_drain (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_drain),
      .done_o (drain_done)
   );

   always_comb begin
      mode_d     = mode_q;
      act_d      = act_q;
      load_drain = 1'b0;
      unique case (mode_q)
         MODE_RUN: begin
            if (stall_take) begin
               if (found) begin
                  mode_d     = MODE_DRAIN;
                  act_d      = pick;
                  load_drain = 1'b1;
               end else begin
                  mode_d = MODE_IDLE;
               end
            end
         end
         MODE_DRAIN: begin
            if (drain_done)
               mode_d = MODE_RUN;
         end
         MODE_IDLE: begin
            if (found) begin
               mode_d     = MODE_DRAIN;
               act_d      = pick;
               load_drain = 1'b1;
            end
         end
         default: mode_d = MODE_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RUN;
         act_q  <= '0;
         free_q <= '1;
      end else begin
         mode_q <= mode_d;
         act_q  <= act_d;
         free_q <= free_d;
      end
   end

   assign active_id_o   = act_q;
   assign issue_valid_o = (mode_q == MODE_RUN);
   assign idle_o        = (mode_q == MODE_IDLE);
endmodule

// File: rtl/ctx_switch_sched_chk.sv
module ctx_switch_sched_chk #(
   parameter int NUM_CTX      = 8,
   parameter int DRAIN_CYCLES = 3,
   parameter int IDW          = $clog2(NUM_CTX)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               stall_i,
   input logic [NUM_CTX-1:0] unblock_i,
   input logic [IDW-1:0]     active_id_o,
   input logic               issue_valid_o,
   input logic               idle_o
);
   localparam int LW = $clog2(DRAIN_CYCLES + 2);
   logic [LW-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         low_cnt <= '0;
      else if (!issue_valid_o && !idle_o) begin
         if (low_cnt != LW'(DRAIN_CYCLES + 1))
            low_cnt <= low_cnt + 1'b1;
      end else
         low_cnt <= '0;
   end

   p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({issue_valid_o, idle_o}));

   p_stay_r10: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid_o && !stall_i |=> issue_valid_o && $stable(active_id_o));

   p_stall_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid_o && stall_i |=> !issue_valid_o);

   p_new_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid_o && stall_i |=> idle_o || (active_id_o != $past(active_id_o)));

   p_drain_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(issue_valid_o) |-> low_cnt == LW'(DRAIN_CYCLES));

   p_drain_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
      low_cnt <= LW'(DRAIN_CYCLES));

   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      idle_o && (unblock_i == '0) |=> idle_o && $stable(active_id_o));

   p_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
      idle_o && (unblock_i != '0) |=> !idle_o && !issue_valid_o);

   p_no_effect_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_valid_o && !idle_o && (low_cnt < LW'(DRAIN_CYCLES - 1)) |=> $stable(active_id_o));
endmodule

bind ctx_switch_sched ctx_switch_sched_chk #(
   .NUM_CTX      (NUM_CTX),
   .DRAIN_CYCLES (DRAIN_CYCLES)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .stall_i       (stall_i),
   .unblock_i     (unblock_i),
   .active_id_o   (active_id_o),
   .issue_valid_o (issue_valid_o),
   .idle_o        (idle_o)
);

// File: tb/ctx_switch_sched_test.sv
module ctx_switch_sched_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stall = 1'b0;
   logic [7:0] unblock = '0;
   logic [2:0] act;
   logic       vld, idl;
   int         n_chk = 0;
   int         n_bad = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   ctx_switch_sched uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .stall_i       (stall),
      .unblock_i     (unblock),
      .active_id_o   (act),
      .issue_valid_o (vld),
      .idle_o        (idl)
   );

   // {stall, unblock[7:0], exp_id[2:0], exp_valid, exp_idle}
   localparam logic [13:0] VEC [18] = '{
      {1'b0, 8'h00, 3'd0, 1'b1, 1'b0},
      {1'b1, 8'h00, 3'd1, 1'b0, 1'b0},
      {1'b1, 8'h00, 3'd1, 1'b0, 1'b0},
      {1'b0, 8'h00, 3'd1, 1'b0, 1'b0},
      {1'b0, 8'h00, 3'd1, 1'b1, 1'b0},
      {1'b1, 8'h00, 3'd2, 1'b0, 1'b0},
      {1'b0, 8'h00, 3'd2, 1'b0, 1'b0},
      {1'b0, 8'h00, 3'd2, 1'b0, 1'b0},
      {1'b0, 8'h00, 3'd2, 1'b1, 1'b0},
      {1'b1, 8'h01, 3'd3, 1'b0, 1'b0},
      {1'b0, 8'h00, 3'd3, 1'b0, 1'b0},
      {1'b0, 8'h00, 3'd3, 1'b0, 1'b0},
      {1'b0, 8'h00, 3'd3, 1'b1, 1'b0},
      {1'b0, 8'h00, 3'd3, 1'b1, 1'b0},
      {1'b1, 8'h00, 3'd4, 1'b0, 1'b0},
      {1'b0, 8'h00, 3'd4, 1'b0, 1'b0},
      {1'b0, 8'h00, 3'd4, 1'b0, 1'b0},
      {1'b0, 8'h00, 3'd4, 1'b1, 1'b0}
   };

   task automatic compare(input logic [2:0] e_act, input logic e_v, input logic e_i,
                          input string tag);
      n_chk++;
      if (act !== e_act || vld !== e_v || idl !== e_i) begin
         n_bad++;
         $display("FAIL %s: got id=%0d valid=%b idle=%b, expected id=%0d valid=%b idle=%b",
                  tag, act, vld, idl, e_act, e_v, e_i);
      end
   endtask

   task automatic step(input logic st, input logic [7:0] ub, input logic [2:0] e_act,
                       input logic e_v, input logic e_i, input string tag);
      stall   = st;
      unblock = ub;
      @(negedge clk);
      stall   = 1'b0;
      unblock = '0;
      compare(e_act, e_v, e_i, tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #400000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      compare(3'd0, 1'b1, 1'b0, "R1 reset state");

      // table walk: R2 order, R3 drain, R8 stall in drain, R9 unblock while running, R10 hold
      for (int i = 0; i < 18; i++) begin
         step(VEC[i][13], VEC[i][12:5], VEC[i][4:2], VEC[i][1], VEC[i][0],
              $sformatf("R2/R3/R8/R9/R10 vector %0d", i));
      end

      // fresh reset
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      compare(3'd0, 1'b1, 1'b0, "R1 reset after run");

      // stall through every context; ctx3 gets an unblock in its stall cycle (R7)
      for (int k = 0; k < 7; k++) begin
         step(1'b1, (k == 3) ? 8'h08 : 8'h00, 3'(k + 1), 1'b0, 1'b0, "R2 walk switch");
         step(1'b0, 8'h00, 3'(k + 1), 1'b0, 1'b0, "R3 walk drain");
         step(1'b0, 8'h00, 3'(k + 1), 1'b0, 1'b0, "R3 walk drain");
         step(1'b0, 8'h00, 3'(k + 1), 1'b1, 1'b0, "R3 walk resume");
      end
      step(1'b1, 8'h00, 3'd7, 1'b0, 1'b1, "R5 R7 R4 all blocked goes idle");
      step(1'b0, 8'h00, 3'd7, 1'b0, 1'b1, "R5 idle held");
      step(1'b0, 8'h00, 3'd7, 1'b0, 1'b1, "R5 idle held");
      step(1'b1, 8'h00, 3'd7, 1'b0, 1'b1, "R8 stall while idle");

      // wake with ctx2 and ctx5 together: search after 7 reaches 2 first
      step(1'b0, 8'h24, 3'd2, 1'b0, 1'b0, "R6 wake picks circular first");
      step(1'b0, 8'h40, 3'd2, 1'b0, 1'b0, "R9 unblock during drain");
      step(1'b0, 8'h00, 3'd2, 1'b0, 1'b0, "R3 wake drain");
      step(1'b0, 8'h00, 3'd2, 1'b1, 1'b0, "R3 wake resume");

      step(1'b1, 8'h00, 3'd5, 1'b0, 1'b0, "R6 idle unblock of ctx5 kept");
      repeat (2) step(1'b0, 8'h00, 3'd5, 1'b0, 1'b0, "R3 drain");
      step(1'b0, 8'h00, 3'd5, 1'b1, 1'b0, "R3 resume");

      step(1'b1, 8'h00, 3'd6, 1'b0, 1'b0, "R9 drain unblock of ctx6 kept");
      repeat (2) step(1'b0, 8'h00, 3'd6, 1'b0, 1'b0, "R3 drain");
      step(1'b0, 8'h00, 3'd6, 1'b1, 1'b0, "R3 resume");

      step(1'b1, 8'h00, 3'd6, 1'b0, 1'b1, "R4 stalled ctx2 ctx5 skipped");
      step(1'b0, 8'h40, 3'd6, 1'b0, 1'b0, "R6 self wake");
      step(1'b0, 8'h00, 3'd6, 1'b0, 1'b0, "R3 self wake drain");
      step(1'b0, 8'h00, 3'd6, 1'b0, 1'b0, "R3 self wake drain");
      step(1'b0, 8'h00, 3'd6, 1'b1, 1'b0, "R3 self wake resume");
      step(1'b0, 8'h00, 3'd6, 1'b1, 1'b0, "R10 hold");

      finish_run();
   end
endmodule